// File: doc/BRIEF.md
# Device Error Classifier and Signaler

This block takes one error event detected by a device function and decides what the function does with it. An event is a one-hot error code, a class flag (correctable or uncorrectable), a flag that marks a nonfatal uncorrectable error as one that may be reported as advisory, and a 16-bit requester source identifier. Configuration registers inside the block hold the masks, the uncorrectable severity bits and the reporting enables. The block updates the device status bits and the correctable and uncorrectable status registers. It then decides whether an error message goes upstream, and with which severity class.

When an error has to be kept, the block asserts a record request toward an external header log, in the same cycle as the event. The log answers with a full indication. If the log is full when a record is requested, the block generates a header-log-overflow correctable error of its own on the following cycle. It handles that error like any other event and gives it the same source identifier. An external strobe in that following cycle is not taken. Configuration is written through a simple address/data write port. The status registers are cleared by writing ones to them.

Top module: `err_signaler`

## Requirements
- R1: The event code is first reduced to the supported bits of its class: bits [15:0] for uncorrectable and bits [7:0] for correctable. If the result is zero or has more than one bit set, the event is dropped: no status changes, no record request and no message.
- R2: After reset the severity register is 16'h003F. Uncorrectable codes 0 (internal), 1 (link protocol), 2 (surprise down), 3 (receiver overflow), 4 (flow-control protocol) and 5 (malformed packet) are fatal. Codes 6 to 15 are nonfatal, and code 8 is unsupported request.
- R3: An uncorrectable error is fatal when its bit in the severity register (address 2) is set and nonfatal otherwise. It sets device status bit 2 (fatal) or bit 1 (nonfatal).
- R4: A correctable error sets device status bit 0 and its bit in the correctable status register. If its bit in the correctable mask (address 0) is set, no message is sent.
- R5: An uncorrectable error whose bit is set in the uncorrectable mask (address 1) still sets its uncorrectable status bit, but it raises no record request and sends no message.
- R6: An unmasked uncorrectable error raises log_req, with log_err equal to its one-hot code, and sets its status bit. A fatal message needs control bit 4 (system-error enable) or bit 2 (fatal enable). A nonfatal message needs bit 4 or bit 1 (nonfatal enable).
- R7: A nonfatal uncorrectable error flagged advisory is handled as correctable code 5. If code 5 is not cor-masked, the error also sets its uncorrectable status bit and is recorded only when it is unmasked in the uncorrectable mask. If code 5 is cor-masked, it sends no message and sets no uncorrectable status.
- R8: An unsupported-request error also sets device status bit 3. When control bit 3 (unsupported-request enable) is clear, no message is sent. For the uncorrectable path this applies only when bit 4 is also clear.
- R9: A correctable message (including advisory) needs control bit 0 (correctable enable).
- R10: A record request while log_full is high causes, one cycle later, a correctable event with code 7 (header log overflow) and the same source identifier.
- R11: msg_valid pulses in the cycle after the event is taken. msg_sev is 0 for correctable, 1 for nonfatal and 2 for fatal, and msg_src is the event's source identifier.
- R12: Status registers are cleared by writing ones: device status at address 4 (bits [3:0]), correctable at address 5 and uncorrectable at address 6. Control is at address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Event strobe |
| evt_status | input | 16 | One-hot error code |
| evt_is_cor | input | 1 | 1 = correctable class |
| evt_adv | input | 1 | Nonfatal may be reported as advisory |
| evt_src | input | 16 | Source identifier |
| log_full | input | 1 | Header log cannot take a record |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Write data |
| dev_sta | output | 4 | Device status: 0 correctable, 1 nonfatal, 2 fatal, 3 unsupported request |
| cor_sta | output | 8 | Correctable status |
| unc_sta | output | 16 | Uncorrectable status |
| msg_valid | output | 1 | Error message pulse |
| msg_sev | output | 2 | Message severity class |
| msg_src | output | 16 | Message source identifier |
| log_req | output | 1 | Record request |
| log_err | output | 16 | Code being recorded |

## Verification
The bench targets several corner cases:
- Multi-bit codes, and codes that lie only in unsupported bits. A design that skips the reduction would send a message or set a bit for them.
- The advisory path with the correctable mask set. A wrong design would still set the uncorrectable status or record the error.
- Unsupported requests while system-error enable is set. A design that applies the unsupported-request gate unconditionally would drop that message.
- The log-full case. A design that loses the overflow event would show no second correctable message with code 7.
- The reset severity of every uncorrectable code, swept one code at a time.

// File: rtl/errsig_pkg.sv
package errsig_pkg;
    parameter int UNC_W  = 16;
    parameter int COR_W  = 8;
    parameter int SRC_W  = 16;
    parameter int ADDR_W = 3;
    parameter int DS_W   = 4;
    parameter int CTL_W  = 5;

    localparam int UE_UR  = 8;
    localparam int CE_ADV = 5;
    localparam int CE_HLO = 7;

    localparam int DS_CED  = 0;
    localparam int DS_NFED = 1;
    localparam int DS_FED  = 2;
    localparam int DS_URD  = 3;

    localparam logic [UNC_W-1:0] UNC_SEV_RST = UNC_W'(16'h003F);

    localparam logic [ADDR_W-1:0] A_CMASK = 3'd0;
    localparam logic [ADDR_W-1:0] A_UMASK = 3'd1;
    localparam logic [ADDR_W-1:0] A_USEV  = 3'd2;
    localparam logic [ADDR_W-1:0] A_CTL   = 3'd3;
    localparam logic [ADDR_W-1:0] A_DSTA  = 3'd4;
    localparam logic [ADDR_W-1:0] A_CSTA  = 3'd5;
    localparam logic [ADDR_W-1:0] A_USTA  = 3'd6;

    typedef enum logic [1:0] {
        SEV_COR      = 2'd0,
        SEV_NONFATAL = 2'd1,
        SEV_FATAL    = 2'd2
    } sev_e;

    typedef struct packed {
        logic serr_en;
        logic ur_en;
        logic fatal_en;
        logic nf_en;
        logic cor_en;
    } ctl_t;

    typedef struct packed {
        logic             accept;
        logic [DS_W-1:0]  set_dev;
        logic [COR_W-1:0] set_cor;
        logic [UNC_W-1:0] set_unc;
        logic             log_req;
        logic             send;
        sev_e             sev;
    } verdict_t;

    function automatic logic single_bit(input logic [UNC_W-1:0] v);
        return (v != '0) && ((v & (v - 1'b1)) == '0);
    endfunction
endpackage

// File: rtl/errsig_cfg.sv
module errsig_cfg
    import errsig_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [UNC_W-1:0]  wr_data,
    output logic [COR_W-1:0]  cor_mask,
    output logic [UNC_W-1:0]  unc_mask,
    output logic [UNC_W-1:0]  unc_sev,
    output ctl_t              ctl
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cor_mask <= '0;
            unc_mask <= '0;
            unc_sev  <= UNC_SEV_RST;
            ctl      <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_CMASK: cor_mask <= wr_data[COR_W-1:0];
                A_UMASK: unc_mask <= wr_data;
                A_USEV:  unc_sev  <= wr_data;
                A_CTL:   ctl      <= ctl_t'(wr_data[CTL_W-1:0]);
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/errsig_classify.sv
module errsig_classify
    import errsig_pkg::*;
(
    input  logic             is_cor,
    input  logic             adv,
    input  logic [UNC_W-1:0] status,
    input  logic [COR_W-1:0] cor_mask,
    input  logic [UNC_W-1:0] unc_mask,
    input  logic [UNC_W-1:0] unc_sev,
    input  ctl_t             ctl,
    output verdict_t         vd
);
    logic [COR_W-1:0] cst;
    logic [COR_W-1:0] cbit;
    logic             ur, fatal, use_cor;

    always_comb begin
        cst     = status[COR_W-1:0];
        ur      = !is_cor && status[UE_UR];
        fatal   = |(status & unc_sev);
        use_cor = is_cor || (!fatal && adv);
        cbit    = is_cor ? cst : COR_W'(1) << CE_ADV;
        vd      = '0;
        vd.sev  = SEV_COR;
        vd.accept = is_cor ? single_bit(UNC_W'(cst)) : single_bit(status);
        if (vd.accept) begin
            vd.set_dev[DS_URD] = ur;
            if (use_cor) begin
                vd.set_dev[DS_CED] = 1'b1;
                vd.set_cor         = cbit;
                if (!(|(cbit & cor_mask))) begin
                    if (!is_cor) begin
                        vd.set_unc = status;
                        vd.log_req = !(|(status & unc_mask));
                    end
                    vd.send = ctl.cor_en && !(ur && !ctl.ur_en);
                end
            end else begin
                if (fatal) vd.set_dev[DS_FED] = 1'b1;
                else       vd.set_dev[DS_NFED] = 1'b1;
                vd.set_unc = status;
                if (!(|(status & unc_mask))) begin
                    vd.log_req = 1'b1;
                    vd.send = !(ur && !ctl.ur_en && !ctl.serr_en) &&
                              (ctl.serr_en || (fatal ? ctl.fatal_en : ctl.nf_en));
                    vd.sev  = fatal ? SEV_FATAL : SEV_NONFATAL;
                end
            end
        end
    end
endmodule

// File: rtl/err_signaler.sv
module err_signaler
    import errsig_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              evt_valid,
    input  logic [UNC_W-1:0]  evt_status,
    input  logic              evt_is_cor,
    input  logic              evt_adv,
    input  logic [SRC_W-1:0]  evt_src,
    input  logic              log_full,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [UNC_W-1:0]  wr_data,
    output logic [DS_W-1:0]   dev_sta,
    output logic [COR_W-1:0]  cor_sta,
    output logic [UNC_W-1:0]  unc_sta,
    output logic              msg_valid,
    output logic [1:0]        msg_sev,
    output logic [SRC_W-1:0]  msg_src,
    output logic              log_req,
    output logic [UNC_W-1:0]  log_err
);
    logic [COR_W-1:0] cor_mask;
    logic [UNC_W-1:0] unc_mask, unc_sev;
    ctl_t             ctl;
    verdict_t         vd;
    logic             ovf_pend;
    logic [SRC_W-1:0] ovf_src;
    logic             proc, act;
    logic             cur_cor, cur_adv;
    logic [UNC_W-1:0] cur_status;
    logic [SRC_W-1:0] cur_src;
    logic [DS_W-1:0]  clr_dev;
    logic [COR_W-1:0] clr_cor;
    logic [UNC_W-1:0] clr_unc;

    errsig_cfg u_cfg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cor_mask(cor_mask), .unc_mask(unc_mask), .unc_sev(unc_sev), .ctl(ctl)
    );

    always_comb begin
        proc       = ovf_pend || evt_valid;
        cur_cor    = ovf_pend ? 1'b1 : evt_is_cor;
        cur_adv    = ovf_pend ? 1'b0 : evt_adv;
        cur_status = ovf_pend ? UNC_W'(1) << CE_HLO : evt_status;
        cur_src    = ovf_pend ? ovf_src : evt_src;
    end

    errsig_classify u_cls (
        .is_cor(cur_cor), .adv(cur_adv), .status(cur_status),
        .cor_mask(cor_mask), .unc_mask(unc_mask), .unc_sev(unc_sev),
        .ctl(ctl), .vd(vd)
    );

    assign act     = proc && vd.accept;
    assign log_req = act && vd.log_req;
    assign log_err = vd.set_unc;
    assign clr_dev = (wr_en && wr_addr == A_DSTA) ? wr_data[DS_W-1:0]  : '0;
    assign clr_cor = (wr_en && wr_addr == A_CSTA) ? wr_data[COR_W-1:0] : '0;
    assign clr_unc = (wr_en && wr_addr == A_USTA) ? wr_data            : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            dev_sta   <= '0;
            cor_sta   <= '0;
            unc_sta   <= '0;
            msg_valid <= 1'b0;
            msg_sev   <= SEV_COR;
            msg_src   <= '0;
            ovf_pend  <= 1'b0;
            ovf_src   <= '0;
        end else begin
            dev_sta   <= (dev_sta & ~clr_dev) | (act ? vd.set_dev : '0);
            cor_sta   <= (cor_sta & ~clr_cor) | (act ? vd.set_cor : '0);
            unc_sta   <= (unc_sta & ~clr_unc) | (act ? vd.set_unc : '0);
            msg_valid <= act && vd.send;
            if (act && vd.send) begin
                msg_sev <= vd.sev;
                msg_src <= cur_src;
            end
            ovf_pend <= log_req && log_full;
            if (log_req && log_full) ovf_src <= evt_src;
        end
    end

    // R1
    reject_multi_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && !ovf_pend && !evt_is_cor && $countones(evt_status) > 1) |=> !msg_valid);

    // R11
    msg_cause_chk: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> $past(evt_valid || ovf_pend));

    // R3
    sev_legal_chk: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> (msg_sev != 2'd3));

    // R6
    log_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        log_req |-> ($countones(log_err) == 1 && !evt_is_cor));

    // R10
    ovf_next_chk: assert property (@(posedge clk) disable iff (rst)
        (log_req && log_full) |=> (!log_req && ovf_pend));

    // R12
    cor_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_addr == A_CSTA) |=> ((cor_sta & $past(cor_sta)) == $past(cor_sta)));
endmodule

// File: tb/err_signaler_test.sv
`timescale 1ns/1ps
module err_signaler_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        evt_valid = 1'b0;
    logic [15:0] evt_status = '0;
    logic        evt_is_cor = 1'b0;
    logic        evt_adv = 1'b0;
    logic [15:0] evt_src = '0;
    logic        log_full = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  dev_sta;
    logic [7:0]  cor_sta;
    logic [15:0] unc_sta;
    logic        msg_valid;
    logic [1:0]  msg_sev;
    logic [15:0] msg_src;
    logic        log_req;
    logic [15:0] log_err;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [7:0]  m_cm = '0;
    logic [15:0] m_um = '0;
    logic [15:0] m_us = 16'h003F;
    logic [4:0]  m_ctl = '0;
    logic [3:0]  m_ds = '0;
    logic [7:0]  m_cs = '0;
    logic [15:0] m_usta = '0;

    always #2.5 clk = ~clk;

    err_signaler uut (
        .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_status(evt_status),
        .evt_is_cor(evt_is_cor), .evt_adv(evt_adv), .evt_src(evt_src),
        .log_full(log_full), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .dev_sta(dev_sta), .cor_sta(cor_sta), .unc_sta(unc_sta),
        .msg_valid(msg_valid), .msg_sev(msg_sev), .msg_src(msg_src),
        .log_req(log_req), .log_err(log_err)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit single(input logic [15:0] v);
        return (v != 0) && ((v & (v - 16'd1)) == 0);
    endfunction

    task automatic model(input logic [15:0] st, input bit cor, input bit adv, input bit full,
                         output bit ev, output logic [1:0] es, output bit lg, output bit ovf);
        logic [7:0] cst, cb;
        bit ur, fat;
        cst = st[7:0];
        ev = 0; es = 2'd0; lg = 0; ovf = 0;
        if (!(cor ? single({8'h00, cst}) : single(st))) return;
        ur  = !cor && st[8];
        fat = |(st & m_us);
        if (cor || (!fat && adv)) begin
            cb = cor ? cst : 8'h20;
            m_ds[0] = 1'b1;
            if (ur) m_ds[3] = 1'b1;
            m_cs |= cb;
            if (!(|(cb & m_cm))) begin
                if (!cor) begin
                    lg = !(|(st & m_um));
                    m_usta |= st;
                end
                ev = m_ctl[0] && !(ur && !m_ctl[3]);
            end
        end else begin
            if (fat) m_ds[2] = 1'b1; else m_ds[1] = 1'b1;
            if (ur) m_ds[3] = 1'b1;
            m_usta |= st;
            if (!(|(st & m_um))) begin
                lg = 1;
                ev = !(ur && !m_ctl[3] && !m_ctl[4]) && (m_ctl[4] || (fat ? m_ctl[2] : m_ctl[1]));
                es = fat ? 2'd2 : 2'd1;
            end
        end
        ovf = lg && full;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        case (a)
            3'd0: m_cm = d[7:0];
            3'd1: m_um = d;
            3'd2: m_us = d;
            3'd3: m_ctl = d[4:0];
            3'd4: m_ds &= ~d[3:0];
            3'd5: m_cs &= ~d[7:0];
            3'd6: m_usta &= ~d;
            default: ;
        endcase
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic chk_sta(input string req);
        chk(req, "dev_sta", 32'(dev_sta), 32'(m_ds));
        chk(req, "cor_sta", 32'(cor_sta), 32'(m_cs));
        chk(req, "unc_sta", 32'(unc_sta), 32'(m_usta));
    endtask

    task automatic send(input string req, input logic [15:0] st, input bit cor, input bit adv,
                        input logic [15:0] src, input bit full);
        bit ev, lg, ovf, ev2, lg2, ovf2;
        logic [1:0] es, es2;
        @(negedge clk);
        evt_valid = 1'b1; evt_status = st; evt_is_cor = cor; evt_adv = adv;
        evt_src = src; log_full = full;
        model(st, cor, adv, full, ev, es, lg, ovf);
        #1;
        chk(req, "log_req", 32'(log_req), 32'(lg));
        if (lg) chk(req, "log_err", 32'(log_err), 32'(st));
        @(negedge clk);
        evt_valid = 1'b0; log_full = 1'b0;
        chk(req, "msg_valid", 32'(msg_valid), 32'(ev));
        if (ev) begin
            chk(req, "msg_sev", 32'(msg_sev), 32'(es));
            chk(req, "msg_src", 32'(msg_src), 32'(src));
        end
        chk_sta(req);
        ev2 = 0; es2 = 0;
        if (ovf) model(16'h0080, 1'b1, 1'b0, 1'b0, ev2, es2, lg2, ovf2);
        @(negedge clk);
        chk(ovf ? "R10" : req, "msg_valid_2", 32'(msg_valid), 32'(ev2));
        if (ev2) begin
            chk("R10", "msg_sev_2", 32'(msg_sev), 32'(es2));
            chk("R10", "msg_src_2", 32'(msg_src), 32'(src));
        end
        chk_sta(ovf ? "R10" : req);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        chk("R12", "reset dev_sta", 32'(dev_sta), 0);
        chk("R12", "reset cor_sta", 32'(cor_sta), 0);
        chk("R12", "reset unc_sta", 32'(unc_sta), 0);
        chk("R11", "reset msg_valid", 32'(msg_valid), 0);

        // R2: default severity sweep with system-error enable
        wr(3'd3, 16'h0010);
        for (int i = 0; i < 16; i++) begin
            send("R2", 16'(1) << i, 1'b0, 1'b0, 16'(16'h100 + i), 1'b0);
            chk("R2", "sev class", 32'(msg_sev), (i < 6) ? 2 : 1);
        end
        wr(3'd6, 16'hFFFF); wr(3'd4, 16'h000F);

        // R3: programmable severity
        wr(3'd2, 16'h0040);
        send("R3", 16'h0040, 1'b0, 1'b0, 16'hA001, 1'b0);
        send("R3", 16'h0001, 1'b0, 1'b0, 16'hA002, 1'b0);
        wr(3'd2, 16'h003F);

        // R6: reporting enables
        wr(3'd3, 16'h0000);
        send("R6", 16'h0004, 1'b0, 1'b0, 16'hB001, 1'b0);
        wr(3'd3, 16'h0004);
        send("R6", 16'h0004, 1'b0, 1'b0, 16'hB002, 1'b0);
        send("R6", 16'h0400, 1'b0, 1'b0, 16'hB003, 1'b0);
        wr(3'd3, 16'h0002);
        send("R6", 16'h0400, 1'b0, 1'b0, 16'hB004, 1'b0);

        // R5: masked uncorrectable
        wr(3'd3, 16'h0010); wr(3'd1, 16'h0080);
        send("R5", 16'h0080, 1'b0, 1'b0, 16'hC001, 1'b0);
        wr(3'd1, 16'h0000);

        // R4 / R9: correctable and its mask
        wr(3'd3, 16'h0001);
        send("R4", 16'h0002, 1'b1, 1'b0, 16'hD001, 1'b0);
        wr(3'd0, 16'h0002);
        send("R4", 16'h0002, 1'b1, 1'b0, 16'hD002, 1'b0);
        wr(3'd0, 16'h0000); wr(3'd3, 16'h0000);
        send("R9", 16'h0008, 1'b1, 1'b0, 16'hD003, 1'b0);

        // R7: advisory nonfatal
        wr(3'd6, 16'hFFFF); wr(3'd5, 16'h00FF); wr(3'd4, 16'h000F);
        wr(3'd3, 16'h0001);
        send("R7", 16'h0200, 1'b0, 1'b1, 16'hE001, 1'b0);
        wr(3'd1, 16'h0200);
        send("R7", 16'h0200, 1'b0, 1'b1, 16'hE002, 1'b0);
        wr(3'd1, 16'h0000); wr(3'd6, 16'hFFFF);
        wr(3'd0, 16'h0020);
        send("R7", 16'h0200, 1'b0, 1'b1, 16'hE003, 1'b0);
        chk("R7", "no unc status when cor-masked", 32'(unc_sta), 0);
        wr(3'd0, 16'h0000);
        send("R7", 16'h0001, 1'b0, 1'b1, 16'hE004, 1'b0);

        // R8: unsupported request gating
        wr(3'd4, 16'h000F); wr(3'd3, 16'h0002);
        send("R8", 16'h0100, 1'b0, 1'b0, 16'hF001, 1'b0);
        chk("R8", "urd bit", 32'(dev_sta[3]), 1);
        wr(3'd3, 16'h0010);
        send("R8", 16'h0100, 1'b0, 1'b0, 16'hF002, 1'b0);
        wr(3'd3, 16'h0001);
        send("R8", 16'h0100, 1'b0, 1'b1, 16'hF003, 1'b0);
        wr(3'd3, 16'h0009);
        send("R8", 16'h0100, 1'b0, 1'b1, 16'hF004, 1'b0);

        // R10: log overflow
        wr(3'd3, 16'h0013);
        send("R10", 16'h0800, 1'b0, 1'b0, 16'h1234, 1'b1);
        wr(3'd5, 16'h00FF);
        send("R10", 16'h0400, 1'b0, 1'b1, 16'h4321, 1'b1);

        // R1: rejection
        wr(3'd6, 16'hFFFF); wr(3'd5, 16'h00FF); wr(3'd4, 16'h000F);
        send("R1", 16'h0011, 1'b0, 1'b0, 16'h7001, 1'b0);
        send("R1", 16'h0000, 1'b0, 1'b0, 16'h7002, 1'b0);
        send("R1", 16'h1000, 1'b1, 1'b0, 16'h7003, 1'b0);
        send("R1", 16'h0006, 1'b1, 1'b0, 16'h7004, 1'b0);
        send("R1", 16'h1001, 1'b1, 1'b0, 16'h7005, 1'b0);

        // R12 / R11: random mix
        for (int n = 0; n < 400; n++) begin
            if ($urandom_range(0, 4) == 0)
                wr(3'($urandom_range(0, 6)), 16'($urandom));
            if ($urandom_range(0, 7) == 0)
                send("R11", 16'($urandom), 1'($urandom), 1'($urandom), 16'($urandom),
                     ($urandom_range(0, 3) == 0));
            else
                send("R11", 16'(1) << $urandom_range(0, 15), 1'($urandom), 1'($urandom),
                     16'($urandom), ($urandom_range(0, 3) == 0));
        end
        wr(3'd6, 16'hFFFF); wr(3'd5, 16'h00FF); wr(3'd4, 16'h000F);
        chk_sta("R12");

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule